// File: doc/BRIEF.md
# Addressed Asynchronous Serial Receiver

This block receives asynchronous serial frames from a single input line. A free-running oversampling enable, sixteen pulses per bit time, drives a slice counter. The line is re-timed by two flops. An idle-high to low change seen on a slice pulse starts a frame. Every bit, the start bit included, is resolved by a two-of-three vote over three consecutive slices at its centre. A start bit that votes high is treated as noise and dropped.

Frames carry eight data bits, least significant first. The ten-bit format ends with a stop bit. The eleven-bit format puts a programmable ninth bit in front of the stop bit. With the filter enabled in the eleven-bit format, a frame is only delivered when its ninth bit is high and its byte equals a slave address over the bit positions selected by a mask. This lets a node ignore traffic that is addressed to other nodes.

A delivered frame raises a sticky done flag. A stop bit that votes low raises a sticky error flag and the frame is dropped. The controlling logic clears each flag through its own input.

Top module: `uart_rx_filter`

## Requirements
- R1: After reset the line is re-timed by two flops. A frame begins only when the re-timed line is seen high on one slice pulse and low on the next, with reception enabled.
- R2: Each bit is taken as the majority of the re-timed line on the 8th, 9th and 10th slices of that bit, counting the start slice as 0. A disturbance lasting one slice pulse cannot change a bit.
- R3: If the start bit votes 1, the receiver returns to idle. Nothing is loaded and no flag changes.
- R4: In ten-bit format (`nine_bit`=0) the eight data bits arrive LSB first and `rx_bit9` is loaded with 0. In eleven-bit format (`nine_bit`=1) the bit after the data is loaded into `rx_bit9`. The format and filter inputs are captured when the start bit is detected.
- R5: A stop bit that votes 0 sets `frame_err` and the frame is not loaded. `frame_err` stays set until `clr_ferr` is high on a clock edge with no new error on that edge.
- R6: With `nine_bit`=1 and `addr_filt`=1, a frame is loaded only if its ninth bit is 1 and ((byte XOR `slave_addr`) AND `slave_mask`) is zero. A mask bit of 0 makes that address bit don't-care. Otherwise the frame is silently dropped.
- R7: An accepted frame loads `rx_data` and `rx_bit9` and sets `rx_done` on the clock edge of the stop bit's third sample. `rx_done` holds until `clr_done`. A frame that completes while `rx_done` is set is discarded and leaves `rx_data` unchanged.
- R8: While `rx_en` is 0 no frame is started, and a frame in progress is abandoned, so `rx_done` cannot rise.
- R9: Reset clears `rx_data`, `rx_bit9`, `rx_done` and `frame_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_tick | input | 1 | Oversampling enable, 16 per bit time |
| rxd | input | 1 | Serial input line, idle high |
| rx_en | input | 1 | Reception enable |
| nine_bit | input | 1 | 1 selects the eleven-bit frame |
| addr_filt | input | 1 | 1 enables address filtering in eleven-bit format |
| slave_addr | input | DATA_W | Address to compare against |
| slave_mask | input | DATA_W | 1 bits take part in the compare |
| clr_done | input | 1 | Clears `rx_done` |
| clr_ferr | input | 1 | Clears `frame_err` |
| rx_data | output | DATA_W | Last accepted byte |
| rx_bit9 | output | 1 | Ninth bit of last accepted frame |
| rx_done | output | 1 | Accepted frame waiting |
| frame_err | output | 1 | Sticky framing error |

## Verification
A slice counter that is off by one or more shifts the vote window away from the bit centre. It shows up as a changed byte only when a disturbance or a frame boundary falls into the shifted window. For that reason, single-slice disturbances near the centre of a bit are injected.

A wrong bit index shows at the ports in the stop-bit cycle of the same frame. It appears as a missing or early `rx_done`, a shifted byte, or a spurious `frame_err`.

A stuck or mislatched format or filter bit shows as a frame that is accepted or refused against the address rule on its completion edge. Because the reference model is compared every clock, any of these faults is reported in the first cycle in which an output differs.

// File: rtl/uart_rx_filter.sv
module uart_rx_filter #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_tick,
  input  logic              rxd,
  input  logic              rx_en,
  input  logic              nine_bit,
  input  logic              addr_filt,
  input  logic [DATA_W-1:0] slave_addr,
  input  logic [DATA_W-1:0] slave_mask,
  input  logic              clr_done,
  input  logic              clr_ferr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              rx_done,
  output logic              frame_err
);
  localparam int BW = $clog2(DATA_W + 3);
  localparam logic [CNT_W-1:0] SMP0 = CNT_W'(1 << (CNT_W - 1));
  localparam logic [CNT_W-1:0] SMP1 = SMP0 + 1'b1;
  localparam logic [CNT_W-1:0] SMP2 = SMP0 + 2'd2;
  localparam logic [BW-1:0] LAST_DATA = BW'(DATA_W);

  logic              sync1, sync2, prev;
  logic              active, nine_l, filt_l;
  logic [CNT_W-1:0]  cnt;
  logic [BW-1:0]     bitn;
  logic [DATA_W-1:0] shreg;
  logic              b9, s_a, s_b;

  wire          vote     = (s_a & s_b) | (s_a & sync2) | (s_b & sync2);
  wire          decide   = sample_tick && active && rx_en && cnt == SMP2;
  wire [BW-1:0] stop_idx = nine_l ? BW'(DATA_W + 2) : BW'(DATA_W + 1);
  wire          at_stop  = decide && bitn == stop_idx;
  wire          match    = ((shreg ^ slave_addr) & slave_mask) == '0;
  wire          accept   = at_stop && vote && !rx_done &&
                           (!(nine_l && filt_l) || (b9 && match));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1  <= 1'b1;
      sync2  <= 1'b1;
      prev   <= 1'b1;
      active <= 1'b0;
      nine_l <= 1'b0;
      filt_l <= 1'b0;
      cnt    <= '0;
      bitn   <= '0;
      shreg  <= '0;
      b9     <= 1'b0;
      s_a    <= 1'b0;
      s_b    <= 1'b0;
    end else begin
      sync1 <= rxd;
      sync2 <= sync1;
      if (sample_tick) prev <= sync2;
      if (!rx_en) begin
        active <= 1'b0;
      end else if (sample_tick) begin
        if (!active) begin
          if (prev && !sync2) begin
            active <= 1'b1;
            cnt    <= CNT_W'(1);
            bitn   <= '0;
            b9     <= 1'b0;
            nine_l <= nine_bit;
            filt_l <= addr_filt;
          end
        end else begin
          cnt <= cnt + 1'b1;
          if (cnt == '1) bitn <= bitn + 1'b1;
          if (cnt == SMP0) s_a <= sync2;
          if (cnt == SMP1) s_b <= sync2;
          if (cnt == SMP2) begin
            if (bitn == '0) begin
              if (vote) active <= 1'b0;
            end else if (bitn == stop_idx) begin
              active <= 1'b0;
            end else if (bitn <= LAST_DATA) begin
              shreg <= {vote, shreg[DATA_W-1:1]};
            end else begin
              b9 <= vote;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data   <= '0;
      rx_bit9   <= 1'b0;
      rx_done   <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      if (accept) begin
        rx_data <= shreg;
        rx_bit9 <= nine_l & b9;
        rx_done <= 1'b1;
      end else if (clr_done) begin
        rx_done <= 1'b0;
      end
      if (at_stop && !vote)  frame_err <= 1'b1;
      else if (clr_ferr)     frame_err <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_filter_chk.sv
module uart_rx_filter_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              nine_bit,
  input logic              addr_filt,
  input logic [DATA_W-1:0] slave_addr,
  input logic [DATA_W-1:0] slave_mask,
  input logic              clr_done,
  input logic              clr_ferr,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_bit9,
  input logic              rx_done,
  input logic              frame_err
);
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && !clr_done |=> rx_done); // R7
  AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> $stable(rx_data) && $stable(rx_bit9)); // R7
  AST_FERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err && !clr_ferr |=> frame_err); // R5
  AST_ADDR_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) && nine_bit && addr_filt |->
      rx_bit9 && (((rx_data ^ slave_addr) & slave_mask) == '0)); // R6
  AST_SHORT_NINTH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) && !nine_bit |-> !rx_bit9); // R4
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !$rose(rx_done)); // R8
endmodule

bind uart_rx_filter uart_rx_filter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .nine_bit(nine_bit),
  .addr_filt(addr_filt), .slave_addr(slave_addr), .slave_mask(slave_mask),
  .clr_done(clr_done), .clr_ferr(clr_ferr), .rx_data(rx_data),
  .rx_bit9(rx_bit9), .rx_done(rx_done), .frame_err(frame_err)
);

// File: tb/sim_uart_rx_filter.sv
`timescale 1ns/1ps
module sim_uart_rx_filter;
  logic clk = 0, rst_n = 0, sample_tick = 0, rxd = 1;
  logic rx_en = 0, nine_bit = 0, addr_filt = 0, clr_done = 0, clr_ferr = 0;
  logic [7:0] slave_addr = 0, slave_mask = 0;
  logic [7:0] rx_data;
  logic rx_bit9, rx_done, frame_err;
  int checks = 0, errors = 0, cyc = 0, tc = 0;

  always #2.5 clk = ~clk;

  uart_rx_filter u0 (.*);

  always @(negedge clk) begin
    tc <= (tc + 1) % 4;
    sample_tick <= (tc == 3);
  end

  // behavioural reference
  int lineq[$];
  int m_active, m_slice, m_s8, m_s9, m_prev, m_nine, m_filt;
  int m_data, m_b9, m_done, m_ferr;
  int bits[0:10];

  always @(posedge clk) begin
    if (!rst_n) begin
      lineq = {1, 1};
      m_active = 0; m_slice = 0; m_prev = 1; m_s8 = 0; m_s9 = 0;
      m_nine = 0; m_filt = 0; m_data = 0; m_b9 = 0; m_done = 0; m_ferr = 0;
    end else begin
      int s, load, setf, nd, nb9;
      s = lineq.pop_front();
      lineq.push_back(int'(rxd));
      load = 0; setf = 0; nd = 0; nb9 = 0;
      if (!rx_en) m_active = 0;
      else if (sample_tick) begin
        if (!m_active) begin
          if (m_prev == 1 && s == 0) begin
            m_active = 1; m_slice = 0; m_nine = nine_bit; m_filt = addr_filt;
          end
        end else begin
          int pos, b;
          m_slice++;
          pos = m_slice % 16; b = m_slice / 16;
          if (pos == 8) m_s8 = s;
          if (pos == 9) m_s9 = s;
          if (pos == 10) begin
            int v;
            v = (m_s8 + m_s9 + s) >= 2;
            bits[b] = v;
            if (b == 0 && v) m_active = 0;
            else if (b == (m_nine ? 10 : 9)) begin
              m_active = 0;
              if (!v) setf = 1;
              else begin
                for (int i = 1; i <= 8; i++) nd |= bits[i] << (i - 1);
                nb9 = m_nine ? bits[9] : 0;
                load = !m_done && (!(m_nine && m_filt) ||
                       (nb9 == 1 && ((nd ^ slave_addr) & slave_mask) == 0));
              end
            end
          end
        end
      end
      if (sample_tick) m_prev = s;
      if (load) begin m_done = 1; m_data = nd; m_b9 = nb9; end
      else if (clr_done) m_done = 0;
      if (setf) m_ferr = 1;
      else if (clr_ferr) m_ferr = 0;
    end
  end

  always @(negedge clk) if (rst_n) begin
    checks++;
    if (rx_data != m_data[7:0] || rx_bit9 != m_b9[0]) begin
      errors++;
      $display("FAIL R4 model: data %h/%0d expected %h/%0d", rx_data, rx_bit9, m_data[7:0], m_b9);
    end
    if (rx_done != m_done[0]) begin
      errors++;
      $display("FAIL R7 model: rx_done %0d expected %0d", rx_done, m_done);
    end
    if (frame_err != m_ferr[0]) begin
      errors++;
      $display("FAIL R5 model: frame_err %0d expected %0d", frame_err, m_ferr);
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic b9, input logic nine,
                      input logic stopv, input int gbit);
    int fr[0:10];
    int n;
    n = nine ? 11 : 10;
    fr[0] = 0;
    for (int i = 0; i < 8; i++) fr[i+1] = d[i];
    if (nine) fr[9] = b9;
    fr[n-1] = stopv;
    for (int i = 0; i < n; i++)
      for (int c = 0; c < 64; c++) begin
        @(negedge clk);
        rxd = (i == gbit && c >= 36 && c < 40) ? !fr[i][0] : fr[i][0];
      end
    @(negedge clk) rxd = 1;
    repeat (64) @(negedge clk);
  endtask

  task automatic pulse_clr_done();
    @(negedge clk) clr_done = 1;
    @(negedge clk) clr_done = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(rx_data, 0, "R9 data"); chk(rx_done, 0, "R9 done"); chk(frame_err, 0, "R9 ferr");
    rst_n = 1;
    repeat (20) @(negedge clk);
    chk(rx_done, 0, "R9 done after release");
    rx_en = 1;
    repeat (70) @(negedge clk);
    send(8'hA5, 0, 0, 1, -1);
    chk(rx_done, 1, "R1 done"); chk(rx_data, 8'hA5, "R4 lsb first"); chk(rx_bit9, 0, "R4 short ninth");
    send(8'h3C, 0, 0, 1, -1);
    chk(rx_data, 8'hA5, "R7 overrun discarded"); chk(rx_done, 1, "R7 held");
    pulse_clr_done();
    chk(rx_done, 0, "R7 cleared");
    nine_bit = 1;
    send(8'h5A, 1, 1, 1, -1);
    chk(rx_data, 8'h5A, "R4 long data"); chk(rx_bit9, 1, "R4 long ninth");
    pulse_clr_done();
    nine_bit = 0;
    send(8'h0F, 0, 0, 1, 3);
    chk(rx_data, 8'h0F, "R2 vote bit2"); chk(rx_done, 1, "R2 done");
    pulse_clr_done();
    send(8'hF0, 0, 0, 1, 6);
    chk(rx_data, 8'hF0, "R2 vote bit5");
    pulse_clr_done();
    @(negedge clk) rxd = 0;
    repeat (8) @(negedge clk);
    rxd = 1;
    repeat (800) @(negedge clk);
    chk(rx_done, 0, "R3 start glitch"); chk(frame_err, 0, "R3 no error");
    send(8'h99, 0, 0, 0, -1);
    chk(frame_err, 1, "R5 set"); chk(rx_done, 0, "R5 dropped");
    repeat (100) @(negedge clk);
    chk(frame_err, 1, "R5 sticky");
    @(negedge clk) clr_ferr = 1;
    @(negedge clk) clr_ferr = 0;
    chk(frame_err, 0, "R5 cleared");
    nine_bit = 1; addr_filt = 1; slave_addr = 8'h40; slave_mask = 8'hF0;
    send(8'h4C, 1, 1, 1, -1);
    chk(rx_done, 1, "R6 masked match"); chk(rx_data, 8'h4C, "R6 data");
    pulse_clr_done();
    send(8'h4C, 0, 1, 1, -1);
    chk(rx_done, 0, "R6 ninth zero rejected");
    send(8'h5C, 1, 1, 1, -1);
    chk(rx_done, 0, "R6 mismatch rejected"); chk(rx_data, 8'h4C, "R6 data kept");
    send(8'h43, 1, 1, 1, -1);
    chk(rx_done, 1, "R6 dont care bits"); chk(rx_data, 8'h43, "R6 data2");
    pulse_clr_done();
    addr_filt = 0; nine_bit = 0; rx_en = 0;
    send(8'h77, 0, 0, 1, -1);
    chk(rx_done, 0, "R8 disabled"); chk(rx_data, 8'h43, "R8 data kept");
    rx_en = 1;
    repeat (70) @(negedge clk);
    send(8'h81, 0, 0, 1, -1);
    chk(rx_data, 8'h81, "R1 reenabled");
    repeat (10) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule